// File: doc/BRIEF.md
# Cascadable Programmable Delay Controller

The block delays a single-bit signal by a whole number of clock cycles chosen by a stored setting. The setting has two parts. A fine field, loaded from a `FINE_W`-bit address bus, picks a delay of one plus its value. An extension bit, loaded from a separate cascade input, moves the stage to its longest tap. That tap is exactly one cycle beyond the longest fine tap. The setting is held in level-sensitive latches. They follow the bus while the latch enable is high and keep their value while it is low.

Two asynchronous override pins take precedence over the bus and the enable. Force-minimum clears the whole setting. Force-maximum loads a fixed fine pattern and sends the stage to its longest tap. The extension bit is brought out on a true/complement pair. Several stages can be chained with no other logic. The true output of a stage drives that stage's own force-maximum. The complement drives the force-minimum of the stage after it. The chained delay then grows monotonically as one extra address line per stage is raised. The stored setting reaches the tap selector only on a clock edge, so the tap never changes in the middle of a cycle.

Top module: `pdly_stage`

## Requirements
- R1: While `latch_en` is high the setting follows `fine_addr` and `casc_in`. While it is low the setting holds, and changes on those inputs have no effect on the delay.
- R2: With the extension bit clear and no override active, the delay D is `fine + 1` cycles, from 1 to 128 at default width. A value sampled from `din` at rising edge n appears on `dout` just after rising edge n+D-1. A new setting takes effect from the next rising edge.
- R3: With the extension bit set, D is 2^FINE_W + 1 cycles (129 at default width). This is exactly one more than the all-ones fine setting.
- R4: While `force_min` is high, the fine field and the extension bit are cleared and D is 1. The address bus and `latch_en` have no effect, and after release the cleared setting remains until the next load.
- R5: While `force_max` is high and `force_min` is low, fine bits 0 and 1 are cleared, all higher fine bits are set, and D is 129. The extension bit is left untouched. After release with `latch_en` low, the pattern remains, so D is 125 when the extension bit is clear.
- R6: When both overrides are high, `force_min` wins and D is 1.
- R7: `cascade` equals the stored extension bit and `cascade_n` is its complement.
- R8: In a two-stage chain, the lower stage's `cascade` drives its own `force_max` and its `cascade_n` drives the upper stage's `force_min`. The bus is shared, and the two extension inputs act as combined code bits 7 and 8. The total delay is then c+2 for combined codes c = 0..255 and 258 for c = 256, strictly rising.
- R9: The tap selection is a register that updates only on a rising clock edge from the setting present at that edge.
- R10: While `rst_n` is low, the delay line and `dout` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one delay step per cycle |
| rst_n | input | 1 | Active-low synchronous reset of the delay line and tap register |
| din | input | 1 | Signal to be delayed |
| fine_addr | input | FINE_W | Fine delay value, loaded when `latch_en` is high |
| casc_in | input | 1 | Extension (cascade control) bit, loaded when `latch_en` is high |
| latch_en | input | 1 | High: setting latches transparent; low: hold |
| force_min | input | 1 | Asynchronous override to the minimum setting |
| force_max | input | 1 | Asynchronous override to the maximum setting |
| dout | output | 1 | Delayed signal |
| cascade | output | 1 | Stored extension bit |
| cascade_n | output | 1 | Complement of `cascade` |

## Verification
The assertions assume that the setting inputs, the overrides and the latch enable are settled at every rising edge, and that the latches have been loaded before reset is released. Values never leave X that way. The stimulus changes these inputs only on falling edges and loads every stage during reset. It then waits two cycles after each setting change before launching a test pulse. It flushes the delay lines after each measurement, so that a pulse still in a line cannot be picked up by a later, longer tap.

// File: rtl/pdly_pkg.sv
package pdly_pkg;

  // Number of taps of one stage: base step, every fine step, one extension step.
  function automatic int unsigned stage_depth(int unsigned fine_w);
    return (32'd1 << fine_w) + 32'd1;
  endfunction

  // Delay in cycles selected by a setting.
  function automatic int unsigned stage_delay(int unsigned fine_w, int unsigned fine,
                                              logic at_max);
    return at_max ? stage_depth(fine_w) : fine + 32'd1;
  endfunction

  // Fine pattern loaded by the force-maximum override: low bits cleared, rest set.
  function automatic int unsigned max_pattern(int unsigned fine_w, int unsigned clr_low);
    return ((32'd1 << fine_w) - 32'd1) & ~((32'd1 << clr_low) - 32'd1);
  endfunction

endpackage

// File: rtl/pdly_code_latch.sv
module pdly_code_latch #(
  parameter int unsigned FINE_W = 7,
  parameter logic [FINE_W-1:0] MAX_PAT = '1
) (
  input  logic              latch_en,
  input  logic [FINE_W-1:0] fine_in,
  input  logic              ext_in,
  input  logic              force_min,
  input  logic              force_max,
  output logic [FINE_W-1:0] fine_q,
  output logic              ext_q
);

  // Fine field: both overrides act on it, minimum first.
  always_latch begin
    if (force_min)      fine_q = '0;
    else if (force_max) fine_q = MAX_PAT;
    else if (latch_en)  fine_q = fine_in;
  end

  // Extension bit: kept as its own variable and left alone by force-maximum,
  // because in a chain its value drives this stage's force-maximum.
  always_latch begin
    if (force_min)     ext_q = 1'b0;
    else if (latch_en) ext_q = ext_in;
  end

endmodule

// File: rtl/pdly_sel_reg.sv
module pdly_sel_reg #(
  parameter int unsigned SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] next_sel,
  output logic [SEL_W-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= SEL_W'(1);
    else        sel_q <= next_sel;
  end

endmodule

// File: rtl/pdly_shift_line.sv
module pdly_shift_line #(
  parameter int unsigned DEPTH = 129
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);

  logic [DEPTH-2:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[DEPTH-3:0], din};
  end

  // Tap k carries din delayed by k registers; tap 0 is din itself.
  assign taps = {sr, din};

  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> sr[0] == $past(din));

endmodule

// File: rtl/pdly_tap_mux.sv
module pdly_tap_mux #(
  parameter int unsigned DEPTH = 129,
  parameter int unsigned SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] taps,
  input  logic [SEL_W-1:0] sel_q,
  output logic             dout
);

  // A delay of D cycles counts this output register, so tap D-1 is chosen.
  logic [SEL_W-1:0] tap_idx;
  assign tap_idx = sel_q - SEL_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= taps[tap_idx];
  end

endmodule

// File: rtl/pdly_stage.sv
module pdly_stage #(
  parameter int unsigned FINE_W  = 7,
  parameter int unsigned CLR_LOW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [FINE_W-1:0] fine_addr,
  input  logic              casc_in,
  input  logic              latch_en,
  input  logic              force_min,
  input  logic              force_max,
  output logic              dout,
  output logic              cascade,
  output logic              cascade_n
);
  import pdly_pkg::*;

  localparam int unsigned DEPTH = stage_depth(FINE_W);
  localparam int unsigned SEL_W = $clog2(DEPTH + 1);
  localparam logic [FINE_W-1:0] MAX_PAT = FINE_W'(max_pattern(FINE_W, CLR_LOW));

  logic [FINE_W-1:0] fine_q;
  logic              ext_q;
  logic              at_max;
  logic [SEL_W-1:0]  next_sel;
  logic [SEL_W-1:0]  sel_q;
  logic [DEPTH-1:0]  taps;

  pdly_code_latch #(.FINE_W(FINE_W), .MAX_PAT(MAX_PAT)) u_latch (
    .latch_en (latch_en),
    .fine_in  (fine_addr),
    .ext_in   (casc_in),
    .force_min(force_min),
    .force_max(force_max),
    .fine_q   (fine_q),
    .ext_q    (ext_q)
  );

  assign cascade   = ext_q;
  assign cascade_n = ~ext_q;

  // The longest tap is taken on a stored extension bit or a live force-maximum.
  assign at_max   = (ext_q | force_max) & ~force_min;
  assign next_sel = SEL_W'(stage_delay(FINE_W, 32'(fine_q), at_max));

  pdly_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .next_sel(next_sel),
    .sel_q   (sel_q)
  );

  pdly_shift_line #(.DEPTH(DEPTH)) u_line (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .taps (taps)
  );

  pdly_tap_mux #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_mux (
    .clk  (clk),
    .rst_n(rst_n),
    .taps (taps),
    .sel_q(sel_q),
    .dout (dout)
  );

  assert_fmin_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_min |-> (fine_q == '0 && !ext_q));

  assert_fmax_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_max && !force_min) |-> fine_q == MAX_PAT);

  assert_fmin_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_min && force_max) |=> sel_q == SEL_W'(1));

  assert_ext_longest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && !force_min) |=> sel_q == SEL_W'(DEPTH));

  // R2 and R9: the tap seen after an edge reflects the fine field held at that edge.
  assert_fine_tap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(force_min) && !$past(force_max) && !$past(ext_q))
      |-> sel_q == SEL_W'($past(fine_q)) + SEL_W'(1));

endmodule

// File: tb/sim_pdly_stage.sv
`timescale 1ns/1ps
module sim_pdly_stage;
  localparam int FW    = 7;
  localparam int DEPTH = (1 << FW) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic [FW-1:0] bus_c = '0, bus_s = '0;
  logic ca = 1'b0, cb = 1'b0, cs = 1'b0;
  logic le_c = 1'b0, le_s = 1'b0;
  logic fmin_s = 1'b0, fmax_s = 1'b0;

  logic mid, dout_c, casc0, casc0_n, casc1, casc1_n;
  logic dout_s, casc_s, casc_s_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // Chain: lower stage u0 forces its own maximum and the upper stage's minimum.
  pdly_stage u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .fine_addr(bus_c), .casc_in(ca),
    .latch_en(le_c), .force_min(1'b0), .force_max(casc0),
    .dout(mid), .cascade(casc0), .cascade_n(casc0_n));

  pdly_stage u1 (
    .clk(clk), .rst_n(rst_n), .din(mid), .fine_addr(bus_c), .casc_in(cb),
    .latch_en(le_c), .force_min(casc0_n), .force_max(1'b0),
    .dout(dout_c), .cascade(casc1), .cascade_n(casc1_n));

  pdly_stage u2 (
    .clk(clk), .rst_n(rst_n), .din(din), .fine_addr(bus_s), .casc_in(cs),
    .latch_en(le_s), .force_min(fmin_s), .force_max(fmax_s),
    .dout(dout_s), .cascade(casc_s), .cascade_n(casc_s_n));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Launch a one-cycle pulse and count rising edges until it shows on the output.
  task automatic measure(input bit chain, output int d);
    @(negedge clk);
    din = 1'b1;
    d = -1;
    for (int n = 1; n <= 3 * DEPTH; n++) begin
      @(negedge clk);
      if (n == 1) din = 1'b0;
      if ((chain ? dout_c : dout_s) == 1'b1) begin
        d = n;
        break;
      end
    end
    repeat (2 * DEPTH + 4) @(negedge clk);
  endtask

  task automatic load_s(input int fine, input bit ext);
    @(negedge clk);
    bus_s = FW'(fine); cs = ext; le_s = 1'b1;
    @(negedge clk);
    le_s = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_c(input int code);
    @(negedge clk);
    bus_c = FW'(code % 128);
    ca = (code >= 128);
    cb = (code >= 256);
    le_c = 1'b1;
    @(negedge clk);
    le_c = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int d, prev;
    // Load every stage while reset is held.
    @(negedge clk);
    le_c = 1'b1; le_s = 1'b1;
    @(negedge clk);
    le_c = 1'b0; le_s = 1'b0;
    din = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 dout during reset", int'(dout_c), 0);
    check("R10 standalone dout during reset", int'(dout_s), 0);
    din = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 cascade after clear load", int'(casc0), 0);
    check("R7 cascade_n after clear load", int'(casc0_n), 1);

    // R2: fine delay.
    load_s(5, 1'b0);
    measure(1'b0, d); check("R2 fine 5", d, 6);
    check("R7 standalone cascade low", int'(casc_s), 0);
    check("R7 standalone cascade_n high", int'(casc_s_n), 1);
    load_s(0, 1'b0);
    measure(1'b0, d); check("R2 fine 0", d, 1);

    // R1: hold while enable low, then follow while it is high.
    load_s(5, 1'b0);
    @(negedge clk); bus_s = FW'(100); cs = 1'b1;
    repeat (2) @(negedge clk);
    measure(1'b0, d); check("R1 hold with enable low", d, 6);
    check("R1 extension held low", int'(casc_s), 0);
    @(negedge clk); cs = 1'b0; le_s = 1'b1; bus_s = FW'(127);
    repeat (2) @(negedge clk);
    measure(1'b0, d); check("R1 transparent all-ones fine", d, 128);
    @(negedge clk); le_s = 1'b0;

    // R3: extension tap.
    load_s(3, 1'b1);
    measure(1'b0, d); check("R3 extension", d, DEPTH);
    check("R7 cascade high", int'(casc_s), 1);
    check("R7 cascade_n low", int'(casc_s_n), 0);

    // R5: force-maximum.
    load_s(3, 1'b0);
    @(negedge clk); fmax_s = 1'b1;
    repeat (2) @(negedge clk);
    measure(1'b0, d); check("R5 force max delay", d, DEPTH);
    check("R5 extension untouched", int'(casc_s), 0);
    @(negedge clk); fmax_s = 1'b0;
    repeat (2) @(negedge clk);
    measure(1'b0, d); check("R5 pattern after release", d, 125);

    // R4: force-minimum overrides bus and enable, and the cleared setting stays.
    load_s(9, 1'b1);
    @(negedge clk); fmin_s = 1'b1; le_s = 1'b1; bus_s = FW'(80); cs = 1'b1;
    repeat (2) @(negedge clk);
    measure(1'b0, d); check("R4 force min delay", d, 1);
    check("R4 cascade cleared", int'(casc_s), 0);
    @(negedge clk); le_s = 1'b0;
    @(negedge clk); fmin_s = 1'b0;
    repeat (2) @(negedge clk);
    measure(1'b0, d); check("R4 cleared after release", d, 1);

    // R6: both overrides.
    load_s(40, 1'b1);
    @(negedge clk); fmin_s = 1'b1; fmax_s = 1'b1;
    repeat (2) @(negedge clk);
    measure(1'b0, d); check("R6 force min wins", d, 1);
    check("R6 cascade low", int'(casc_s), 0);
    @(negedge clk); fmin_s = 1'b0; fmax_s = 1'b0;

    // R8: full sweep of the two-stage chain.
    prev = 0;
    for (int c = 0; c <= 256; c++) begin
      load_c(c);
      measure(1'b1, d);
      check($sformatf("R8 chain code %0d", c), d, (c < 256) ? c + 2 : 258);
      if (d <= prev) begin
        checks++; fails++;
        $display("FAIL R8 monotonic at %0d: got %0d expected more than %0d", c, d, prev);
      end
      prev = d;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule